// File: doc/BRIEF.md
# Board System Control Port Block

This block sits on a byte-wide I/O bus and gathers the board-level control and identification ports in one place. A host issues single-cycle read or write strobes with a 16-bit port address. Writes to the control ports update live outputs: a soft-reset request, a little-endian mode bit, a disk activity light, a 4-bit system control field and an I/O map mode bit. Writes to two lock ports produce a one-cycle pulse toward an external non-volatile memory. Reads return either the stored control values or fixed board identification and status bytes. Unmapped ports read as 0xFF.

The bus has no back-pressure. The block accepts a strobe in every cycle, so there is no ready signal. At most one of the read and write strobes may be high in a cycle. The read result is registered. It appears on the cycle after the read strobe and holds until the next read.

Top module: `sysctl_regfile`

## Requirements
- R1: A write to port 0x0092 sets `soft_reset` from data bit 0 and `little_endian` from data bit 1, starting on the cycle after the strobe. A read of 0x0092 returns 0x00.
- R2: A write to port 0x0808 sets `disk_light` from data bit 0. A read of 0x0808 returns 0xFF.
- R3: A write to port 0x081C stores data bits 3:0 in `sys_ctl`. A read of 0x081C returns that value in bits 3:0, with bits 7:4 zero.
- R4: A write to port 0x0850 stores data bit 0 in `map_mode`. A read of 0x0850 returns 0x00 or 0x01 to match.
- R5: A write to port 0x0810 raises `lock1_pulse`, and a write to port 0x0812 raises `lock2_pulse`. The pulse is high for exactly the one cycle after the strobe, whatever the data value.
- R6: Reads of the identification and status ports return fixed bytes: 0x0800→0xEF, 0x0802→0xAD, 0x0803→0xE0, 0x080C→0x3C, 0x0810→0x39, 0x0818→0x00, 0x0823→0x03.
- R7: Writes to ports 0x0800, 0x0802, 0x0803 and 0x0814, and to any unmapped port, change no output.
- R8: A read of port 0x0814 returns 0x00. A read of any port not listed in R1 to R6 returns 0xFF.
- R9: `io_rdata` changes only on the cycle after a read strobe, and holds between reads.
- R10: A synchronous active-high `rst` clears every stored control output, both pulses and `io_rdata` to zero.
- R11: With no write strobe, the control outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 16 | Port address |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rdata | output | 8 | Registered read data |
| soft_reset | output | 1 | Soft-reset request level |
| little_endian | output | 1 | Little-endian mode |
| disk_light | output | 1 | Disk activity light |
| sys_ctl | output | 4 | System control field |
| map_mode | output | 1 | I/O map mode: 0 contiguous, 1 split |
| lock1_pulse | output | 1 | One-cycle toggle request for lock 1 |
| lock2_pulse | output | 1 | One-cycle toggle request for lock 2 |

## Verification
The assertions check on every cycle:
- each control write lands in its output one cycle later;
- a lock pulse appears only after a write to its own port;
- outputs and read data hold when no strobe is present;
- the strobes are mutually exclusive;
- sample identification and unmapped reads return their bytes.

Only the bench's scenarios can show the following:
- the full table of fixed bytes;
- that writes to identification, cache-invalidate and unmapped ports leave every output untouched;
- the zero-extension of read-back values;
- the effect of a reset in the middle of a run.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int CTL_W  = 4;
  localparam int NLOCK  = 2;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_SPECIAL,
    SEL_CPU_ID,
    SEL_FEATURE,
    SEL_STATUS,
    SEL_EQUIP,
    SEL_DISK,
    SEL_LOCK1,
    SEL_LOCK2,
    SEL_CACHE_INV,
    SEL_KEY,
    SEL_SYSCTL,
    SEL_CACHE_STAT,
    SEL_MAP
  } port_sel_e;

  localparam logic [15:0] PA_SPECIAL    = 16'h0092;
  localparam logic [15:0] PA_CPU_ID     = 16'h0800;
  localparam logic [15:0] PA_FEATURE    = 16'h0802;
  localparam logic [15:0] PA_STATUS     = 16'h0803;
  localparam logic [15:0] PA_DISK       = 16'h0808;
  localparam logic [15:0] PA_EQUIP      = 16'h080C;
  localparam logic [15:0] PA_LOCK1      = 16'h0810;
  localparam logic [15:0] PA_LOCK2      = 16'h0812;
  localparam logic [15:0] PA_CACHE_INV  = 16'h0814;
  localparam logic [15:0] PA_KEY        = 16'h0818;
  localparam logic [15:0] PA_SYSCTL     = 16'h081C;
  localparam logic [15:0] PA_CACHE_STAT = 16'h0823;
  localparam logic [15:0] PA_MAP        = 16'h0850;

  localparam logic [7:0] VAL_CPU_ID     = 8'hEF;
  localparam logic [7:0] VAL_FEATURE    = 8'hAD;
  localparam logic [7:0] VAL_STATUS     = 8'hE0;
  localparam logic [7:0] VAL_EQUIP      = 8'h3C;
  localparam logic [7:0] VAL_EXT_FEAT   = 8'h39;
  localparam logic [7:0] VAL_KEY        = 8'h00;
  localparam logic [7:0] VAL_CACHE_STAT = 8'h03;
  localparam logic [7:0] VAL_ZERO       = 8'h00;
  localparam logic [7:0] VAL_UNMAPPED   = 8'hFF;

  localparam port_sel_e LOCK_SEL [NLOCK] = '{SEL_LOCK1, SEL_LOCK2};

  typedef struct packed {
    logic             soft_reset;
    logic             little_endian;
    logic             disk_light;
    logic [CTL_W-1:0] sys_ctl;
    logic             map_mode;
  } ctl_state_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output port_sel_e     sel
);

  always_comb begin
    case (addr)
      AW'(PA_SPECIAL):    sel = SEL_SPECIAL;
      AW'(PA_CPU_ID):     sel = SEL_CPU_ID;
      AW'(PA_FEATURE):    sel = SEL_FEATURE;
      AW'(PA_STATUS):     sel = SEL_STATUS;
      AW'(PA_DISK):       sel = SEL_DISK;
      AW'(PA_EQUIP):      sel = SEL_EQUIP;
      AW'(PA_LOCK1):      sel = SEL_LOCK1;
      AW'(PA_LOCK2):      sel = SEL_LOCK2;
      AW'(PA_CACHE_INV):  sel = SEL_CACHE_INV;
      AW'(PA_KEY):        sel = SEL_KEY;
      AW'(PA_SYSCTL):     sel = SEL_SYSCTL;
      AW'(PA_CACHE_STAT): sel = SEL_CACHE_STAT;
      AW'(PA_MAP):        sel = SEL_MAP;
      default:            sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/sysctl_ctrl_regs.sv
module sysctl_ctrl_regs
  import sysctl_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CTL_W,
  parameter int NL = NLOCK
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  port_sel_e     sel,
  input  logic [DW-1:0] wdata,
  output ctl_state_t    state,
  output logic [NL-1:0] lock_pulse
);

  localparam int RST_BIT    = 0;
  localparam int ENDIAN_BIT = 1;

  ctl_state_t state_q;
  logic       unused_wdata;

  assign unused_wdata = ^wdata[DW-1:CW];

  // Control fields: each updates only on a write to its own port.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_SPECIAL: begin
          state_q.soft_reset    <= wdata[RST_BIT];
          state_q.little_endian <= wdata[ENDIAN_BIT];
        end
        SEL_DISK:   state_q.disk_light <= wdata[0];
        SEL_SYSCTL: state_q.sys_ctl    <= wdata[CW-1:0];
        SEL_MAP:    state_q.map_mode   <= wdata[0];
        default:    state_q <= state_q;
      endcase
    end
  end

  // One registered pulse per lock port, data ignored.
  for (genvar g = 0; g < NL; g++) begin : g_lock
    logic pulse_q;
    always_ff @(posedge clk) begin
      if (rst) pulse_q <= 1'b0;
      else     pulse_q <= wr && (sel == LOCK_SEL[g]);
    end
    assign lock_pulse[g] = pulse_q;
  end

  assign state = state_q;

endmodule

// File: rtl/sysctl_readmux.sv
module sysctl_readmux
  import sysctl_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  port_sel_e     sel,
  input  ctl_state_t    state,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] rd_next;
  logic [DW-1:0] rdata_q;
  logic          unused_state;

  assign unused_state = state.soft_reset ^ state.little_endian ^ state.disk_light;

  always_comb begin
    case (sel)
      SEL_SPECIAL:    rd_next = DW'(VAL_ZERO);
      SEL_CPU_ID:     rd_next = DW'(VAL_CPU_ID);
      SEL_FEATURE:    rd_next = DW'(VAL_FEATURE);
      SEL_STATUS:     rd_next = DW'(VAL_STATUS);
      SEL_EQUIP:      rd_next = DW'(VAL_EQUIP);
      SEL_LOCK1:      rd_next = DW'(VAL_EXT_FEAT);
      SEL_CACHE_INV:  rd_next = DW'(VAL_ZERO);
      SEL_KEY:        rd_next = DW'(VAL_KEY);
      SEL_SYSCTL:     rd_next = DW'(state.sys_ctl);
      SEL_CACHE_STAT: rd_next = DW'(VAL_CACHE_STAT);
      SEL_MAP:        rd_next = DW'(state.map_mode);
      default:        rd_next = DW'(VAL_UNMAPPED);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_next;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = CTL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  input  logic          io_rd,
  input  logic          io_wr,
  output logic [DW-1:0] io_rdata,
  output logic          soft_reset,
  output logic          little_endian,
  output logic          disk_light,
  output logic [CW-1:0] sys_ctl,
  output logic          map_mode,
  output logic          lock1_pulse,
  output logic          lock2_pulse
);

  port_sel_e        sel;
  ctl_state_t       state;
  logic [NLOCK-1:0] lock_pulse;

  sysctl_decode #(.AW(AW)) u_decode (
    .addr (io_addr),
    .sel  (sel)
  );

  sysctl_ctrl_regs #(.DW(DW), .CW(CW), .NL(NLOCK)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr         (io_wr),
    .sel        (sel),
    .wdata      (io_wdata),
    .state      (state),
    .lock_pulse (lock_pulse)
  );

  sysctl_readmux #(.DW(DW)) u_rmux (
    .clk   (clk),
    .rst   (rst),
    .rd    (io_rd),
    .sel   (sel),
    .state (state),
    .rdata (io_rdata)
  );

  assign soft_reset    = state.soft_reset;
  assign little_endian = state.little_endian;
  assign disk_light    = state.disk_light;
  assign sys_ctl       = state.sys_ctl;
  assign map_mode      = state.map_mode;
  assign lock1_pulse   = lock_pulse[0];
  assign lock2_pulse   = lock_pulse[1];

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] io_addr,
  input logic [7:0]  io_wdata,
  input logic        io_rd,
  input logic        io_wr,
  input logic [7:0]  io_rdata,
  input logic        soft_reset,
  input logic        little_endian,
  input logic        disk_light,
  input logic [3:0]  sys_ctl,
  input logic        map_mode,
  input logic        lock1_pulse,
  input logic        lock2_pulse
);

  logic unused_hi;
  assign unused_hi = ^io_wdata[7:4];

  p_special_r1: assert property (@(posedge clk) disable iff (rst)
    io_wr && io_addr == 16'h0092 |=>
      soft_reset == $past(io_wdata[0]) && little_endian == $past(io_wdata[1]));

  p_disk_r2: assert property (@(posedge clk) disable iff (rst)
    io_wr && io_addr == 16'h0808 |=> disk_light == $past(io_wdata[0]));

  p_sysctl_r3: assert property (@(posedge clk) disable iff (rst)
    io_wr && io_addr == 16'h081C |=> sys_ctl == $past(io_wdata[3:0]));

  p_map_r4: assert property (@(posedge clk) disable iff (rst)
    io_wr && io_addr == 16'h0850 |=> map_mode == $past(io_wdata[0]));

  p_lock1_fire_r5: assert property (@(posedge clk) disable iff (rst)
    io_wr && io_addr == 16'h0810 |=> lock1_pulse && !lock2_pulse);

  p_lock1_cause_r5: assert property (@(posedge clk) disable iff (rst)
    lock1_pulse |-> $past(io_wr) && $past(io_addr) == 16'h0810);

  p_lock2_cause_r5: assert property (@(posedge clk) disable iff (rst)
    lock2_pulse |-> $past(io_wr) && $past(io_addr) == 16'h0812);

  p_cpu_id_r6: assert property (@(posedge clk) disable iff (rst)
    io_rd && io_addr == 16'h0800 |=> io_rdata == 8'hEF);

  p_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
    io_rd && io_addr[15:12] != 4'h0 |=> io_rdata == 8'hFF);

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && io_wr));

  p_ctl_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !io_wr |=> $stable({soft_reset, little_endian, disk_light, sys_ctl, map_mode}));

endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .io_addr       (io_addr),
  .io_wdata      (io_wdata),
  .io_rd         (io_rd),
  .io_wr         (io_wr),
  .io_rdata      (io_rdata),
  .soft_reset    (soft_reset),
  .little_endian (little_endian),
  .disk_light    (disk_light),
  .sys_ctl       (sys_ctl),
  .map_mode      (map_mode),
  .lock1_pulse   (lock1_pulse),
  .lock2_pulse   (lock2_pulse)
);

// File: tb/sim_sysctl_regfile.sv
module sim_sysctl_regfile;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_rdata;
  logic        soft_reset, little_endian, disk_light, map_mode;
  logic [3:0]  sys_ctl;
  logic        lock1_pulse, lock2_pulse;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit comparing = 1'b0;

  // Reference model state
  bit       m_rst_o, m_le, m_disk, m_map, m_l1, m_l2;
  bit [3:0] m_ctl;
  bit [7:0] m_rdata;
  string    m_rtag = "R10";

  always #2.5 clk = ~clk;

  sysctl_regfile u0 (
    .clk, .rst, .io_addr, .io_wdata, .io_rd, .io_wr, .io_rdata,
    .soft_reset, .little_endian, .disk_light, .sys_ctl, .map_mode,
    .lock1_pulse, .lock2_pulse
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [7:0] ref_read(input bit [15:0] a);
    case (a)
      16'h0092: return 8'h00;
      16'h0800: return 8'hEF;
      16'h0802: return 8'hAD;
      16'h0803: return 8'hE0;
      16'h080C: return 8'h3C;
      16'h0810: return 8'h39;
      16'h0814: return 8'h00;
      16'h0818: return 8'h00;
      16'h081C: return {4'h0, m_ctl};
      16'h0823: return 8'h03;
      16'h0850: return {7'h0, m_map};
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic string read_tag(input bit [15:0] a);
    case (a)
      16'h0092: return "R1";
      16'h0808: return "R2";
      16'h081C: return "R3";
      16'h0850: return "R4";
      16'h0800, 16'h0802, 16'h0803, 16'h080C, 16'h0810, 16'h0818, 16'h0823: return "R6";
      default:  return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_rst_o = 0; m_le = 0; m_disk = 0; m_map = 0; m_ctl = 0;
      m_l1 = 0; m_l2 = 0; m_rdata = 0; m_rtag = "R10";
    end else begin
      if (io_rd) begin
        m_rdata = ref_read(io_addr);
        m_rtag  = read_tag(io_addr);
      end
      m_l1 = io_wr && io_addr == 16'h0810;
      m_l2 = io_wr && io_addr == 16'h0812;
      if (io_wr) begin
        if (io_addr == 16'h0092) begin m_rst_o = io_wdata[0]; m_le = io_wdata[1]; end
        if (io_addr == 16'h0808) m_disk = io_wdata[0];
        if (io_addr == 16'h081C) m_ctl  = io_wdata[3:0];
        if (io_addr == 16'h0850) m_map  = io_wdata[0];
      end
    end
  end

  always @(negedge clk) begin
    if (comparing) begin
      chk("R1 soft_reset", soft_reset, m_rst_o);
      chk("R1 little_endian", little_endian, m_le);
      chk("R2 disk_light", disk_light, m_disk);
      chk("R3 sys_ctl", sys_ctl, m_ctl);
      chk("R4 map_mode", map_mode, m_map);
      chk("R5 lock1_pulse", lock1_pulse, m_l1);
      chk("R5 lock2_pulse", lock2_pulse, m_l2);
      chk({m_rtag, " R9 io_rdata"}, io_rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic op(input bit r, input bit w, input bit [15:0] a, input bit [7:0] d);
    @(negedge clk);
    io_rd = r; io_wr = w; io_addr = a; io_wdata = d;
  endtask

  task automatic wr(input bit [15:0] a, input bit [7:0] d); op(0, 1, a, d); endtask
  task automatic rd(input bit [15:0] a); op(1, 0, a, 8'h00); endtask
  task automatic idle(); op(0, 0, 16'h0000, 8'h00); endtask

  function automatic logic [7:0] outs();
    return {soft_reset, little_endian, disk_light, sys_ctl, map_mode};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R10 reset outputs", {outs(), lock1_pulse, lock2_pulse, io_rdata}, '0);
    comparing = 1'b1;

    // R1 special port
    wr(16'h0092, 8'h03); wr(16'h0092, 8'h02); wr(16'h0092, 8'h01); rd(16'h0092);
    // R2 disk light
    wr(16'h0808, 8'h01); rd(16'h0808); wr(16'h0808, 8'hFE); idle();
    // R3 system control
    wr(16'h081C, 8'hA7); rd(16'h081C); wr(16'h081C, 8'h5C); rd(16'h081C);
    // R4 map mode
    wr(16'h0850, 8'hFF); rd(16'h0850); wr(16'h0850, 8'h02); rd(16'h0850);
    // R5 lock pulses, various data, back-to-back
    wr(16'h0810, 8'h00); idle(); wr(16'h0812, 8'h55); idle();
    wr(16'h0810, 8'hFF); wr(16'h0812, 8'h00); wr(16'h0810, 8'h01); idle(); idle();
    // R6 fixed values
    rd(16'h0800); rd(16'h0802); rd(16'h0803); rd(16'h080C);
    rd(16'h0810); rd(16'h0818); rd(16'h0823);
    // R8 cache-invalidate and unmapped reads
    rd(16'h0814); rd(16'h0801); rd(16'h0812); rd(16'h0900); rd(16'hFFFF); idle();

    // R7 writes to read-only and unmapped ports: set a known state first
    wr(16'h0092, 8'h03); wr(16'h0808, 8'h01); wr(16'h081C, 8'h09); wr(16'h0850, 8'h01);
    wr(16'h0800, 8'h00); wr(16'h0802, 8'h00); wr(16'h0803, 8'h00);
    wr(16'h0814, 8'h00); wr(16'h0900, 8'h00); wr(16'h080C, 8'h00); idle();
    chk("R7 state after ignored writes", outs(), {1'b1, 1'b1, 1'b1, 4'h9, 1'b1});
    rd(16'h081C); idle();
    chk("R7 readback after ignored writes", io_rdata, 8'h09);

    // R11 idle and reads leave controls alone
    repeat (5) idle();
    rd(16'h0800); rd(16'h0850); idle();
    chk("R11 controls held", outs(), {1'b1, 1'b1, 1'b1, 4'h9, 1'b1});

    // R10 mid-run reset
    @(negedge clk); rst = 1'b1; io_rd = 0; io_wr = 0;
    @(negedge clk); rst = 1'b0;
    chk("R10 mid-run reset", {outs(), io_rdata}, '0);
    rd(16'h081C); idle();

    comparing = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule